// File: doc/BRIEF.md
# Streaming Signed Sample Requantizer

This block narrows signed samples carried in a stream that is qualified by a valid strobe. Each sample has a real and an imaginary part. Both parts go through the same two steps with the same compile-time settings. First, a fixed number of low bits is removed, either by truncating toward minus infinity or by rounding to nearest with halves going away from zero. A rounding carry out of the largest positive value can either saturate or wrap. Second, the result is fitted into the output word. Surplus high bits are either saturated or simply dropped. Saturation can be asymmetric, with the full two's-complement range, or symmetric about zero.

The stream has no back-pressure. There is no ready signal: a sample is taken on every rising clock edge where `in_valid` is high, and the result appears exactly two cycles later. Cycles where `in_valid` is low consume nothing. The start-of-block and end-of-block marks travel beside the data with the same two-cycle delay. All options are parameters, fixed at build time. The design requires `OUT_W` to be no larger than `IN_W - LSB_W`, and `OUT_W` to be at least 2.

Top module: `rq_requant`

## Requirements
- R1: `out_valid`, `out_sob` and `out_eob` equal `in_valid`, `in_sob` and `in_eob` from exactly two rising edges earlier. The sample taken on an edge with `in_valid` high appears on `out_re`/`out_im` together with that delayed `out_valid`.
- R2: While `rst_n` is low, `out_valid`, `out_sob`, `out_eob`, `out_re` and `out_im` are all zero.
- R3: A cycle with `in_valid` low consumes no sample. Two edges later `out_valid` is low, and `out_re`/`out_im` keep the last valid result (zero if there has been none since reset).
- R4: With `ROUND`=0, the kept value is the input shifted arithmetically right by `LSB_W` bits, which is floor division by 2^LSB_W.
- R5: With `ROUND`=1, the kept value is the input divided by 2^LSB_W and rounded to nearest. Exact halves go away from zero: with defaults, 0x008000 gives +1 and 0xFF8000 gives -1.
- R6: With `ROUND`=1, a rounding carry can push the kept value above the largest positive value of the `IN_W-LSB_W`-bit width. With `ROUND_CLIP`=1 that value saturates to the largest positive value. With `ROUND_CLIP`=0 it wraps to the most negative value: with defaults, 0x7F8000 gives 127 or -128 respectively.
- R7: With `MSB_CLIP`=1 and `CLIP_SYM`=0, values outside the `OUT_W`-bit range saturate to -2^(OUT_W-1) or 2^(OUT_W-1)-1. Values inside the range pass unchanged.
- R8: With `MSB_CLIP`=1 and `CLIP_SYM`=1, the lower limit is -(2^(OUT_W-1)-1), so the most negative code never appears on the output.
- R9: With `MSB_CLIP`=0, the output is the low `OUT_W` bits of the kept value in two's complement. `CLIP_SYM` then has no effect.
- R10: The real and imaginary parts are processed independently with identical settings. Each output part depends only on its own input part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present this cycle |
| in_sob | input | 1 | Start-of-block mark, delayed with the data |
| in_eob | input | 1 | End-of-block mark, delayed with the data |
| in_re | input | IN_W | Real part, signed two's complement |
| in_im | input | IN_W | Imaginary part, signed two's complement |
| out_valid | output | 1 | Output sample present this cycle |
| out_sob | output | 1 | Delayed start-of-block mark |
| out_eob | output | 1 | Delayed end-of-block mark |
| out_re | output | OUT_W | Requantized real part |
| out_im | output | OUT_W | Requantized imaginary part |

## Verification
Several properties are checked on every cycle by assertions:
- the two-cycle alignment of the valid and block marks;
- the data holding still after a cycle with no sample;
- the rounding stage never turning a non-negative input negative when carry saturation is on;
- in-range values passing the saturation stage unchanged;
- the most negative code never appearing in symmetric mode;
- the low bits being copied through in wrap mode.

Only the bench scenarios show that the numeric results are right. The bench builds all sixteen option combinations for two bit-width geometries. It drives the extreme inputs, exact and near rounding half-points, and random samples with gaps in the valid stream. It then compares every output word against its own arithmetic model.

// File: rtl/rq_pkg.sv
package rq_pkg;
  // number of sample parts carried per stream word (real, imaginary)
  localparam int RQ_PARTS = 2;

  typedef struct packed {
    logic valid;
    logic sob;
    logic eob;
  } rq_side_t;
endpackage

// File: rtl/rq_lsb_round.sv
module rq_lsb_round #(
  parameter int IN_W       = 24,
  parameter int LSB_W      = 16,
  parameter bit ROUND      = 1'b1,
  parameter bit ROUND_CLIP = 1'b0,
  localparam int QW        = IN_W - LSB_W
) (
  input  logic [IN_W-1:0] x,
  output logic [QW-1:0]   q
);
  logic          sgn;
  logic          carry;
  logic [QW:0]   wide;
  logic          ovf;

  assign sgn = x[IN_W-1];

  // carry into the kept bits: half of one kept LSB added for
  // non-negative inputs, half minus one for negative ones, so halves
  // move away from zero
  generate
    if (!ROUND) begin : g_trunc
      assign carry = 1'b0;
    end else if (LSB_W == 1) begin : g_rnd1
      assign carry = x[0] & ~sgn;
    end else begin : g_rnd
      assign carry = x[LSB_W-1] & (~sgn | (|x[LSB_W-2:0]));
    end
  endgenerate

  assign wide = {sgn, x[IN_W-1:LSB_W]} + {{QW{1'b0}}, carry};
  // only a positive value can exceed the kept range, and only by one
  assign ovf  = ~wide[QW] & wide[QW-1];

  assign q = (ROUND_CLIP && ovf) ? {1'b0, {(QW-1){1'b1}}} : wide[QW-1:0];
endmodule

// File: rtl/rq_msb_fit.sv
module rq_msb_fit #(
  parameter int QW    = 8,
  parameter int OUT_W = 8,
  parameter bit CLIP  = 1'b1,
  parameter bit SYM   = 1'b0
) (
  input  logic [QW-1:0]    q,
  output logic [OUT_W-1:0] y
);
  localparam logic [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEGV = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] MINV = SYM ? (NEGV + 1'b1) : NEGV;

  logic [OUT_W-1:0] low;
  logic             fits;

  assign low = q[OUT_W-1:0];

  generate
    if (QW > OUT_W) begin : g_narrow
      assign fits = (q[QW-1:OUT_W-1] == {(QW-OUT_W+1){q[QW-1]}});
    end else begin : g_same
      assign fits = 1'b1;
    end
  endgenerate

  always_comb begin
    if (!CLIP)                    y = low;
    else if (!fits)               y = q[QW-1] ? MINV : MAXV;
    else if (SYM && low == NEGV)  y = MINV;
    else                          y = low;
  end
endmodule

// File: rtl/rq_lane.sv
module rq_lane #(
  parameter int IN_W       = 24,
  parameter int LSB_W      = 16,
  parameter int OUT_W      = 8,
  parameter bit ROUND      = 1'b1,
  parameter bit ROUND_CLIP = 1'b0,
  parameter bit MSB_CLIP   = 1'b1,
  parameter bit CLIP_SYM   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_in,
  input  logic             v_mid,
  input  logic [IN_W-1:0]  x,
  output logic [OUT_W-1:0] y
);
  localparam int QW   = IN_W - LSB_W;
  localparam int OMAX = (1 << (OUT_W - 1)) - 1;
  localparam int OMIN = CLIP_SYM ? -OMAX : -OMAX - 1;

  logic [QW-1:0]    q_comb;
  logic [QW-1:0]    q1;
  logic [OUT_W-1:0] y_comb;

  rq_lsb_round #(
    .IN_W(IN_W), .LSB_W(LSB_W), .ROUND(ROUND), .ROUND_CLIP(ROUND_CLIP)
  ) u_round (
    .x(x), .q(q_comb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    q1 <= '0;
    else if (v_in) q1 <= q_comb;
  end

  rq_msb_fit #(
    .QW(QW), .OUT_W(OUT_W), .CLIP(MSB_CLIP), .SYM(CLIP_SYM)
  ) u_fit (
    .q(q1), .y(y_comb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     y <= '0;
    else if (v_mid) y <= y_comb;
  end

  generate
    if (ROUND_CLIP) begin : g_rc_chk
      // R6
      round_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && !x[IN_W-1]) |=> !q1[QW-1]);
    end
    if (MSB_CLIP) begin : g_clip_chk
      // R7
      sat_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_mid && $signed(q1) <= OMAX && $signed(q1) >= OMIN)
          |=> y == $past(q1[OUT_W-1:0]));
      if (CLIP_SYM) begin : g_sym_chk
        // R8
        sym_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
          v_mid |=> $signed(y) != -(OMAX + 1));
      end
    end else begin : g_wrap_chk
      // R9
      wrap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_mid |=> y == $past(q1[OUT_W-1:0]));
    end
  endgenerate
endmodule

// File: rtl/rq_requant.sv
module rq_requant
  import rq_pkg::*;
#(
  parameter int IN_W       = 24,
  parameter int LSB_W      = 16,
  parameter int OUT_W      = 8,
  parameter bit ROUND      = 1'b1,
  parameter bit ROUND_CLIP = 1'b0,
  parameter bit MSB_CLIP   = 1'b1,
  parameter bit CLIP_SYM   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sob,
  input  logic             in_eob,
  input  logic [IN_W-1:0]  in_re,
  input  logic [IN_W-1:0]  in_im,
  output logic             out_valid,
  output logic             out_sob,
  output logic             out_eob,
  output logic [OUT_W-1:0] out_re,
  output logic [OUT_W-1:0] out_im
);
  rq_side_t side1, side2;
  logic [IN_W-1:0]  part_in  [RQ_PARTS];
  logic [OUT_W-1:0] part_out [RQ_PARTS];

  assign part_in[0] = in_re;
  assign part_in[1] = in_im;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      side1 <= '0;
      side2 <= '0;
    end else begin
      side1 <= '{valid: in_valid, sob: in_sob, eob: in_eob};
      side2 <= side1;
    end
  end

  // R10: one identical lane per part
  generate
    for (genvar p = 0; p < RQ_PARTS; p++) begin : g_part
      rq_lane #(
        .IN_W(IN_W), .LSB_W(LSB_W), .OUT_W(OUT_W), .ROUND(ROUND),
        .ROUND_CLIP(ROUND_CLIP), .MSB_CLIP(MSB_CLIP), .CLIP_SYM(CLIP_SYM)
      ) u_lane (
        .clk(clk), .rst_n(rst_n), .v_in(in_valid), .v_mid(side1.valid),
        .x(part_in[p]), .y(part_out[p])
      );
    end
  endgenerate

  assign out_valid = side2.valid;
  assign out_sob   = side2.sob;
  assign out_eob   = side2.eob;
  assign out_re    = part_out[0];
  assign out_im    = part_out[1];

  // edges seen since reset, for the latency check
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n)            warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R1
  valid_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (out_valid == $past(in_valid, 2) &&
                        out_sob == $past(in_sob, 2) &&
                        out_eob == $past(in_eob, 2)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !side1.valid |=> ($stable(out_re) && $stable(out_im)));
endmodule

// File: tb/rq_requant_test.sv
module rq_requant_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCFG = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sob = 1'b0, in_eob = 1'b0;
  logic [23:0] in_re = '0, in_im = '0;

  logic       ov  [NCFG];
  logic       osb [NCFG];
  logic       oeb [NCFG];
  logic [7:0] ore [NCFG];
  logic [7:0] oim [NCFG];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // config index: bit0 ROUND, bit1 ROUND_CLIP, bit2 MSB_CLIP, bit3 CLIP_SYM,
  // bit4 selects LSB_W=12 instead of 16
  generate
    for (genvar c = 0; c < NCFG; c++) begin : g_cfg
      rq_requant #(
        .IN_W(24), .LSB_W(c[4] ? 12 : 16), .OUT_W(8),
        .ROUND(c[0]), .ROUND_CLIP(c[1]), .MSB_CLIP(c[2]), .CLIP_SYM(c[3])
      ) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sob(in_sob),
        .in_eob(in_eob), .in_re(in_re), .in_im(in_im),
        .out_valid(ov[c]), .out_sob(osb[c]), .out_eob(oeb[c]),
        .out_re(ore[c]), .out_im(oim[c])
      );
    end
  endgenerate

  function automatic logic [7:0] model(logic [23:0] xin, int c);
    int lsb = c[4] ? 12 : 16;
    int qw = 24 - lsb;
    longint x = longint'($signed(xin));
    longint half = longint'(1) <<< (lsb - 1);
    longint r, qmax, lo;
    if (c[0]) r = (x >= 0) ? ((x + half) >>> lsb) : ((x + half - 1) >>> lsb);
    else      r = x >>> lsb;
    qmax = (longint'(1) <<< (qw - 1)) - 1;
    if (r > qmax) r = c[1] ? qmax : r - (longint'(1) <<< qw);
    if (c[2]) begin
      lo = c[3] ? -127 : -128;
      if (r > 127) r = 127;
      if (r < lo)  r = lo;
    end
    return r[7:0];
  endfunction

  function automatic string tag_of(int c, bit im);
    string rt, mt;
    rt = !c[0] ? "R4" : (c[1] ? "R6" : "R5");
    mt = !c[2] ? "R9" : (c[3] ? "R8" : "R7");
    return $sformatf("%s/%s%s", rt, mt, im ? "/R10" : "");
  endfunction

  task automatic chk(bit ok, string tag, int c, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cfg %0d actual %0h expected %0h", tag, c, act, exp);
    end
  endtask

  // pipeline of driven inputs: d1 one negedge ago, d2 two ago
  logic        d1_v = 0, d1_s = 0, d1_e = 0, d2_v = 0, d2_s = 0, d2_e = 0;
  logic [23:0] d1_re = 0, d1_im = 0, d2_re = 0, d2_im = 0;
  logic [7:0]  last_re [NCFG];
  logic [7:0]  last_im [NCFG];

  task automatic step(logic v, logic s, logic e, logic [23:0] re, logic [23:0] im);
    @(negedge clk);
    for (int c = 0; c < NCFG; c++) begin
      logic [7:0] er, ei;
      // R1 alignment of valid and block marks
      chk(ov[c] == d2_v, "R1 valid", c, ov[c], d2_v);
      chk(osb[c] == d2_s && oeb[c] == d2_e, "R1 marks", c,
          {osb[c], oeb[c]}, {d2_s, d2_e});
      if (d2_v) begin
        er = model(d2_re, c);
        ei = model(d2_im, c);
        last_re[c] = er;
        last_im[c] = ei;
        chk(ore[c] == er, tag_of(c, 1'b0), c, ore[c], er);
        chk(oim[c] == ei, tag_of(c, 1'b1), c, oim[c], ei);
      end else begin
        // R3 no sample consumed, outputs hold
        chk(ore[c] == last_re[c] && oim[c] == last_im[c], "R3 hold", c,
            {ore[c], oim[c]}, {last_re[c], last_im[c]});
      end
    end
    d2_v = d1_v; d2_s = d1_s; d2_e = d1_e; d2_re = d1_re; d2_im = d1_im;
    d1_v = v; d1_s = s; d1_e = e; d1_re = re; d1_im = im;
    in_valid = v; in_sob = s; in_eob = e; in_re = re; in_im = im;
  endtask

  logic [23:0] corners [16] = '{
    24'h7FFFFF, 24'h800000, 24'h008000, 24'hFF8000,
    24'h7F8000, 24'h7F7FFF, 24'h000800, 24'hFFF800,
    24'h7FF800, 24'h807FFF, 24'h000000, 24'hFFFFFF,
    24'h018000, 24'hFE8000, 24'hFF8001, 24'hFF7FFF
  };

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20571);
    for (int c = 0; c < NCFG; c++) begin
      last_re[c] = '0;
      last_im[c] = '0;
    end
    repeat (3) @(negedge clk);
    // R2 reset state
    for (int c = 0; c < NCFG; c++)
      chk(!ov[c] && !osb[c] && !oeb[c] && ore[c] == 0 && oim[c] == 0,
          "R2 reset", c, {ov[c], osb[c], oeb[c], ore[c], oim[c]}, 0);
    rst_n = 1'b1;
    // directed corners, im carries a different corner to show lane independence
    for (int i = 0; i < 16; i++)
      step(1'b1, i == 0, i == 15, corners[i], corners[(i + 5) % 16]);
    // gaps with changing inputs that must be ignored
    step(1'b0, 1'b0, 1'b0, 24'h123456, 24'h654321);
    step(1'b0, 1'b1, 1'b0, 24'h7FFFFF, 24'h800000);
    step(1'b1, 1'b0, 1'b1, 24'hFF8000, 24'h008000);
    // random mix: full range and near half-points
    for (int i = 0; i < 3000; i++) begin
      logic [23:0] a, b;
      int lsb;
      lsb = ($urandom % 2) ? 12 : 16;
      a = $urandom;
      b = $urandom;
      if ($urandom % 3 == 0) begin
        a = (a & ~((24'h1 << lsb) - 1)) | (24'h1 << (lsb - 1));
        if ($urandom % 2 == 1) a = a + 24'(($urandom % 3)) - 24'd1;
      end
      step(($urandom % 4) != 0, ($urandom % 8) == 0, ($urandom % 8) == 0, a, b);
    end
    step(1'b0, 1'b0, 1'b0, 24'h0, 24'h0);
    step(1'b0, 1'b0, 1'b0, 24'h0, 24'h0);
    step(1'b0, 1'b0, 1'b0, 24'h0, 24'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule